// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block is the sending half of an asynchronous serial port. A processor writes a character into a one-entry holding register. As soon as the shifter is free, the character moves into a shift register and goes out on the line as one start bit, 5 to 8 data bits sent least-significant first, and one stop bit. Every bit lasts 16 pulses of an externally supplied 16X baud enable. Because there are two register stages, software can write the next character while the current one is still being sent.

An active-low clear-to-send input decides when a new character may begin. Dropping it never cuts off a character that is already being sent; only the following one is held back, and the line rests at mark. A loop-mode input forces the line to mark and lets characters drain without looking at clear-to-send. A synchronous reset empties both stages and parks the line. Two flags report the state of the block: one says the holding register is free, and the other says both stages are empty.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A frame is a 0 start bit, then N data bits with bit 0 first, then a 1 stop bit. N is selected by `char_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. `char_len` is sampled when the character enters the shifter. Written bits at position N and above have no effect on the line.
- R3: Each start, data and stop bit is held on `txd` for exactly 16 `baud_tick` pulses.
- R4: `hold_empty` is 0 in the cycle that follows any write (`wr_en` high at a clock edge).
- R5: When the shifter is idle and clear-to-send is true, a written character moves to the shifter on the next clock edge. From then on `hold_empty` is 1 and `txd` carries the start bit.
- R6: If a character is waiting and clear-to-send is true when a stop bit ends, the next start bit follows with no idle bit time in between.
- R7: While `cts_n` is 1 and loop mode is off, no new character starts, `txd` stays 1, and a waiting character stays in the holding register (`hold_empty` stays 0).
- R8: A character already being sent when `cts_n` goes to 1 finishes complete and intact.
- R9: While `loop_mode` is 1, `txd` is 1 and characters move from the holding register to the shifter regardless of `cts_n`.
- R10: `tx_done` is 1 exactly when the holding register is empty and the shifter is idle.
- R11: A reset during a frame returns the line to 1 and sets `hold_empty` and `tx_done` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 8 | Character to send |
| char_len | input | 2 | Number of data bits, encoded as 5 plus this value |
| cts_n | input | 1 | Clear-to-send, active low |
| loop_mode | input | 1 | Forces the line to mark and ignores clear-to-send |
| txd | output | 1 | Serial line, where 1 is mark |
| hold_empty | output | 1 | Holding register is free |
| tx_done | output | 1 | Holding register and shifter are both empty |

## Verification
A line monitor samples `txd` on every baud pulse and compares it with frames that bench functions build from the written data and length. A bit that is one tick short or long, or a length decoded wrongly, shows up as a mismatch at once. It also counts idle ticks between frames; a design that inserts a gap bit between back-to-back characters fails that count. Other directed cases target specific mistakes:
- Clear-to-send dropped in mid-character: a design that aborts the character on the spot breaks the frame, and one that keeps sending lets the queued character out early.
- Loop mode: a design that still drives the line is caught by the monitor as an unexpected start bit, and one that waits for clear-to-send leaves `hold_empty` low.
- Reset during a frame: this exposes a line or flags left in their mid-frame state.

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       cts_n,
  input  logic       loop_mode,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_done
);
  localparam int TW = $clog2(OVERSAMPLE);

  logic          hold_full;
  logic [7:0]    hold_data;
  logic          busy;
  logic [9:0]    shreg;
  logic [TW-1:0] tick_cnt;
  logic [3:0]    bit_idx;
  logic [3:0]    last_idx;

  logic [3:0] nbits;
  logic [7:0] payload;
  logic       end_of_bit, end_of_frame, start_ok, load;

  assign nbits        = 4'd5 + {2'b00, char_len};
  assign payload      = hold_data | (8'hFF << nbits);
  assign end_of_bit   = busy && baud_tick && (tick_cnt == TW'(OVERSAMPLE - 1));
  assign end_of_frame = end_of_bit && (bit_idx == last_idx);
  assign start_ok     = loop_mode || !cts_n;
  assign load         = hold_full && start_ok && (!busy || end_of_frame);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_en) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      shreg    <= '1;
      tick_cnt <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      shreg    <= {1'b1, payload, 1'b0};
      tick_cnt <= '0;
      bit_idx  <= '0;
      last_idx <= nbits + 4'd1;
    end else if (end_of_frame) begin
      busy     <= 1'b0;
      shreg    <= '1;
      tick_cnt <= '0;
    end else if (busy && baud_tick) begin
      if (end_of_bit) begin
        tick_cnt <= '0;
        bit_idx  <= bit_idx + 4'd1;
        shreg    <= {1'b1, shreg[9:1]};
      end else begin
        tick_cnt <= tick_cnt + TW'(1);
      end
    end
  end

  assign txd        = (rst || loop_mode || !busy) ? 1'b1 : shreg[0];
  assign hold_empty = !hold_full;
  assign tx_done    = !hold_full && !busy;

  assert_empty_clears_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !hold_empty);

  assert_no_start_without_cts_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!cts_n || loop_mode));

  assert_waiting_char_held_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_full && cts_n && !loop_mode) |=> !hold_empty);

  assert_bit_index_range_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bit_idx <= last_idx && last_idx >= 4'd6 && last_idx <= 4'd9));

  assert_bit_held_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !baud_tick) |=> ($stable(shreg) && $stable(tick_cnt)));
endmodule

// File: tb/uart_tx_flow_bench.sv
module uart_tx_flow_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'b11;
  logic       cts_n = 1'b0;
  logic       loop_mode = 1'b0;
  logic       txd, hold_empty, tx_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  uart_tx_flow u_uart_tx_flow (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .char_len(char_len), .cts_n(cts_n),
    .loop_mode(loop_mode), .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  always #4 clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    div = (div == 2) ? 0 : div + 1;
    baud_tick <= (div == 2);
  end

  function automatic logic frame_bit(input logic [7:0] d, input logic [1:0] len, input int i);
    int n;
    n = 5 + int'(len);
    if (i == 0) return 1'b0;
    if (i <= n) return d[i-1];
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [9:0] q[$];
  logic [9:0] cur;
  bit in_frame = 1'b0;
  int bidx = 0, scnt = 0, frame_bad = 0;
  int frames_done = 0, idle_ticks = 0, last_gap = -1;

  always @(negedge clk) begin
    #1;
    if (rst) begin
      in_frame = 1'b0;
      q.delete();
      idle_ticks = 0;
    end else if (baud_tick) begin
      if (!in_frame) begin
        if (txd == 1'b0) begin
          if (q.size() == 0) begin
            chk(1'b0, "R2 unexpected start bit", 0, 1);
          end else begin
            cur = q.pop_front();
            in_frame = 1'b1;
            bidx = 0; scnt = 0; frame_bad = 0;
            last_gap = idle_ticks;
            idle_ticks = 0;
          end
        end else begin
          idle_ticks++;
        end
      end
      if (in_frame) begin
        if (txd !== frame_bit(cur[7:0], cur[9:8], bidx) && frame_bad == 0) begin
          frame_bad = 1;
          $display("FAIL R2/R3: bit %0d sample %0d actual %0b expected %0b",
                   bidx, scnt, txd, frame_bit(cur[7:0], cur[9:8], bidx));
        end
        scnt++;
        if (scnt == 16) begin
          scnt = 0;
          bidx++;
          if (bidx == 5 + int'(cur[9:8]) + 2) begin
            in_frame = 1'b0;
            frames_done++;
            checks++;
            if (frame_bad != 0) errors++;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] len, input bit push);
    @(negedge clk);
    char_len = len;
    wr_data  = d;
    wr_en    = 1'b1;
    if (push) q.push_back({len, d});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_hold_empty();
    while (!hold_empty) @(negedge clk);
  endtask

  task automatic wait_frames(input int target);
    while (frames_done < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!tx_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty after reset", int'(hold_empty), 1);
    chk(tx_done == 1'b1, "R1/R10 tx_done after reset", int'(tx_done), 1);

    // R4 and R5: a write clears the flag and the character then moves on immediately
    @(negedge clk);
    char_len = 2'b11; wr_data = 8'hA5; wr_en = 1'b1; q.push_back({2'b11, 8'hA5});
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk(hold_empty == 1'b0, "R4 hold_empty after write", int'(hold_empty), 0);
    chk(tx_done == 1'b0, "R10 tx_done after write", int'(tx_done), 0);
    @(negedge clk);
    #1;
    chk(hold_empty == 1'b1, "R5 hold_empty after move", int'(hold_empty), 1);
    chk(txd == 1'b0, "R5 start bit on line", int'(txd), 0);
    chk(tx_done == 1'b0, "R10 tx_done while shifting", int'(tx_done), 0);
    wait_frames(1);
    wait_idle();
    chk(tx_done == 1'b1, "R10 tx_done after frame", int'(tx_done), 1);

    // R2: 5-bit characters whose upper written bits are set
    send(8'hE0, 2'b00, 1'b1);
    wait_idle();
    send(8'hFF, 2'b00, 1'b1);
    wait_idle();
    send(8'h9A, 2'b01, 1'b1);
    wait_idle();
    chk(frames_done == 4, "R2 frame count", frames_done, 4);

    // R6: back-to-back characters leave no gap
    send(8'h3C, 2'b10, 1'b1);
    wait_hold_empty();
    send(8'hC3, 2'b11, 1'b1);
    wait_frames(6);
    chk(last_gap == 0, "R6 idle ticks between frames", last_gap, 0);
    wait_idle();

    // R7: nothing starts while clear-to-send is false
    @(negedge clk); cts_n = 1'b1;
    send(8'h55, 2'b11, 1'b1);
    repeat (300) @(negedge clk);
    #1;
    chk(hold_empty == 1'b0, "R7 character held", int'(hold_empty), 0);
    chk(txd == 1'b1, "R7 line at mark", int'(txd), 1);
    chk(frames_done == 6, "R7 no frame sent", frames_done, 6);
    @(negedge clk); cts_n = 1'b0;
    wait_frames(7);
    wait_idle();

    // R8: clear-to-send dropped mid-frame; the current character finishes, the next waits
    send(8'h6B, 2'b11, 1'b1);
    wait_hold_empty();
    send(8'h94, 2'b10, 1'b1);
    repeat (150) @(negedge clk);
    cts_n = 1'b1;
    wait_frames(8);
    repeat (300) @(negedge clk);
    #1;
    chk(hold_empty == 1'b0, "R8/R7 next character held", int'(hold_empty), 0);
    chk(txd == 1'b1, "R8 line parked after frame", int'(txd), 1);
    chk(frames_done == 8, "R8 only current frame sent", frames_done, 8);
    @(negedge clk); cts_n = 1'b0;
    wait_frames(9);
    wait_idle();

    // R9: loop mode holds the line at mark and ignores clear-to-send
    @(negedge clk); loop_mode = 1'b1; cts_n = 1'b1;
    send(8'h00, 2'b11, 1'b0);
    @(negedge clk);
    #1;
    chk(hold_empty == 1'b1, "R9 moves despite cts false", int'(hold_empty), 1);
    begin
      int low = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        #1;
        if (txd !== 1'b1) low++;
      end
      chk(low == 0, "R9 line at mark in loop mode", low, 0);
    end
    chk(tx_done == 1'b1, "R9/R10 loop character drained", int'(tx_done), 1);
    @(negedge clk); loop_mode = 1'b0; cts_n = 1'b0;
    chk(frames_done == 9, "R9 no frame on line", frames_done, 9);

    // R11: reset in the middle of a frame
    send(8'h0F, 2'b11, 1'b1);
    wait_hold_empty();
    send(8'hF0, 2'b11, 1'b1);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    chk(txd == 1'b1, "R11 line at mark", int'(txd), 1);
    chk(hold_empty == 1'b1, "R11 hold_empty set", int'(hold_empty), 1);
    chk(tx_done == 1'b1, "R11 tx_done set", int'(tx_done), 1);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    begin
      int base;
      base = frames_done;
      // random frames: R2 R3 R6 under mixed lengths, data and spacing
      for (int k = 0; k < 60; k++) begin
        logic [7:0] d;
        logic [1:0] l;
        d = 8'($urandom);
        l = 2'($urandom);
        send(d, l, 1'b1);
        if ($urandom_range(0, 2) == 0) wait_idle();
        else wait_hold_empty();
      end
      wait_idle();
      chk(frames_done == base + 60, "R2/R3 random frames all sent", frames_done, base + 60);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule